// File: doc/BRIEF.md
# Bufferless Ring Stop Router

This block sits at one node of a unidirectional local ring. Each cycle the ring delivers one slot, which is either empty or holds a single flit made of a destination node id and a payload. A flit bound for another node travels on unchanged. A flit bound for this node is handed to the local consumer. When a slot is empty, or has just been emptied by a delivery, a flit waiting at the local source is multiplexed into it. The ring has no storage and no stall signal, so ring traffic never waits.

The ring path has two registers. A link register captures the incoming slot. The routing decision works on that register. A router register then drives the outgoing ring, so every hop takes exactly two cycles. The local consumer may refuse a flit addressed to this node. The flit is then not held anywhere. It stays in its slot, goes around the ring and is offered again on a later lap. The local source uses a valid/ready handshake and keeps its flit steady until ready is seen.

The node's own id is a parameter. The destination field width comes from the number of nodes on the ring.

Top module: `rs_ring_stop`

## Requirements
- R1: A valid ring flit whose destination is not this node leaves on the ring output exactly two cycles after it arrives, with destination and payload unchanged.
- R2: A valid ring flit whose destination equals the node id is presented on the drop port (drop_vld high, payload on drop_data) in the cycle after it arrives on the ring input.
- R3: A flit taken by the drop port (drop_vld and drop_rdy both high) frees its slot: one cycle later the ring output carries an empty slot (tx_vld low), unless a local flit was accepted into that slot.
- R4: When drop_rdy is low while drop_vld is high, the flit is not lost. It leaves on the ring output the next cycle with its destination equal to the node id and its payload intact.
- R5: add_rdy is high exactly when the slot under decision is empty or is being freed in the same cycle by a completed drop.
- R6: A local flit accepted (add_vld and add_rdy both high) appears on the ring output in the following cycle with its destination and payload.
- R7: Circulating traffic has priority. While a slot holds a flit that is not leaving through the drop port, add_rdy is low and the pending local flit is not taken.
- R8: After synchronous active-high reset with an idle ring input, tx_vld and drop_vld are low and add_rdy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_vld | input | 1 | Incoming ring slot holds a flit |
| rx_dest | input | DEST_W | Destination node of incoming flit |
| rx_data | input | PAY_W | Payload of incoming flit |
| tx_vld | output | 1 | Outgoing ring slot holds a flit |
| tx_dest | output | DEST_W | Destination node of outgoing flit |
| tx_data | output | PAY_W | Payload of outgoing flit |
| add_vld | input | 1 | Local source offers a flit |
| add_dest | input | DEST_W | Destination of offered flit |
| add_data | input | PAY_W | Payload of offered flit |
| add_rdy | output | 1 | Offered flit is taken this cycle |
| drop_vld | output | 1 | Flit for this node is offered to the consumer |
| drop_data | output | PAY_W | Payload of delivered flit |
| drop_rdy | input | 1 | Consumer accepts the delivered flit |

## Verification
A corrupted link register shows in the next cycle as a wrong drop_vld or add_rdy, and on the ring output one cycle after that. A corrupted router register shows directly on tx_vld, tx_dest or tx_data in the cycle it holds. A wrong routing choice, such as a flit that is dropped and also forwarded, or an injection that overwrites a flit, shows within two cycles as a duplicated, missing or replaced slot on the ring output. The bench compares every output against a reference model on every cycle, so each such fault is caught in the cycle where it first becomes visible at the ports.

// File: rtl/ringstop_pkg.sv
package ringstop_pkg;

    localparam int RING_NODES = 8;
    localparam int DEST_W     = (RING_NODES > 1) ? $clog2(RING_NODES) : 1;
    localparam int PAY_W      = 32;

    typedef logic [DEST_W-1:0] node_id_t;
    typedef logic [PAY_W-1:0]  payload_t;

    typedef struct packed {
        logic     vld;
        node_id_t dest;
        payload_t data;
    } slot_t;

    localparam slot_t EMPTY_SLOT = '0;

    typedef enum logic [1:0] {
        OUT_EMPTY  = 2'd0,
        OUT_FORWARD = 2'd1,
        OUT_LOCAL  = 2'd2
    } out_src_e;

    function automatic logic bound_here(slot_t s, node_id_t me);
        return s.vld && (s.dest == me);
    endfunction

endpackage

// File: rtl/rs_slot_reg.sv
module rs_slot_reg
    import ringstop_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  slot_t d,
    output slot_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= EMPTY_SLOT;
        else     q <= d;
    end
endmodule

// File: rtl/rs_route_ctl.sv
module rs_route_ctl
    import ringstop_pkg::*;
#(
    parameter node_id_t MY_ID = '0
) (
    input  slot_t    cur,
    input  logic     drop_rdy,
    input  slot_t    add_slot,
    output logic     drop_vld,
    output logic     add_rdy,
    output out_src_e src,
    output slot_t    nxt
);
    logic freed;

    always_comb begin
        drop_vld = bound_here(cur, MY_ID);
        freed    = drop_vld && drop_rdy;
        add_rdy  = !cur.vld || freed;
        if (cur.vld && !freed)   src = OUT_FORWARD;
        else if (add_slot.vld)   src = OUT_LOCAL;
        else                     src = OUT_EMPTY;
        unique case (src)
            OUT_FORWARD: nxt = cur;
            OUT_LOCAL:   nxt = add_slot;
            default:     nxt = EMPTY_SLOT;
        endcase
    end
endmodule

// File: rtl/rs_ring_stop.sv
module rs_ring_stop
    import ringstop_pkg::*;
#(
    parameter int unsigned NODE_ID = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_vld,
    input  logic [DEST_W-1:0] rx_dest,
    input  logic [PAY_W-1:0]  rx_data,
    output logic              tx_vld,
    output logic [DEST_W-1:0] tx_dest,
    output logic [PAY_W-1:0]  tx_data,
    input  logic              add_vld,
    input  logic [DEST_W-1:0] add_dest,
    input  logic [PAY_W-1:0]  add_data,
    output logic              add_rdy,
    output logic              drop_vld,
    output logic [PAY_W-1:0]  drop_data,
    input  logic              drop_rdy
);
    localparam node_id_t MY_ID = node_id_t'(NODE_ID);

    slot_t    rx_slot, link_q, route_d, out_q, add_slot;
    out_src_e src;

    assign rx_slot  = '{vld: rx_vld, dest: rx_dest, data: rx_data};
    assign add_slot = '{vld: add_vld, dest: add_dest, data: add_data};

    rs_slot_reg u_link (.clk(clk), .rst(rst), .d(rx_slot), .q(link_q));

    rs_route_ctl #(.MY_ID(MY_ID)) u_route (
        .cur(link_q), .drop_rdy(drop_rdy), .add_slot(add_slot),
        .drop_vld(drop_vld), .add_rdy(add_rdy), .src(src), .nxt(route_d)
    );

    rs_slot_reg u_router (.clk(clk), .rst(rst), .d(route_d), .q(out_q));

    assign tx_vld    = out_q.vld;
    assign tx_dest   = out_q.dest;
    assign tx_data   = out_q.data;
    assign drop_data = link_q.data;

    p_pass_two_cycles_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(rx_vld, 2) && $past(rx_dest, 2) != MY_ID)
        |-> (tx_vld && tx_dest == $past(rx_dest, 2) && tx_data == $past(rx_data, 2)));

    p_drop_origin_r2: assert property (@(posedge clk) disable iff (rst)
        (drop_vld && !$past(rst))
        |-> ($past(rx_vld) && $past(rx_dest) == MY_ID && drop_data == $past(rx_data)));

    p_freed_slot_r3: assert property (@(posedge clk) disable iff (rst)
        (drop_vld && drop_rdy && !add_vld) |=> !tx_vld);

    p_refused_stays_r4: assert property (@(posedge clk) disable iff (rst)
        (drop_vld && !drop_rdy) |=> (tx_vld && tx_dest == MY_ID));

    p_ready_free_r5: assert property (@(posedge clk) disable iff (rst)
        (add_rdy && drop_vld) |-> drop_rdy);

    p_inject_next_r6: assert property (@(posedge clk) disable iff (rst)
        (add_vld && add_rdy)
        |=> (tx_vld && tx_dest == $past(add_dest) && tx_data == $past(add_data)));

endmodule

// File: tb/test_rs_ring_stop.sv
`timescale 1ns/1ps
module test_rs_ring_stop;
    import ringstop_pkg::*;

    localparam int ME = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_vld = 1'b0, add_vld = 1'b0, drop_rdy = 1'b1;
    logic [DEST_W-1:0] rx_dest = '0, add_dest = '0;
    logic [PAY_W-1:0]  rx_data = '0, add_data = '0;
    logic tx_vld, add_rdy, drop_vld;
    logic [DEST_W-1:0] tx_dest;
    logic [PAY_W-1:0]  tx_data, drop_data;

    int checks = 0, fails = 0;
    bit done = 0;

    rs_ring_stop #(.NODE_ID(ME)) i_rs_ring_stop (
        .clk(clk), .rst(rst),
        .rx_vld(rx_vld), .rx_dest(rx_dest), .rx_data(rx_data),
        .tx_vld(tx_vld), .tx_dest(tx_dest), .tx_data(tx_data),
        .add_vld(add_vld), .add_dest(add_dest), .add_data(add_data), .add_rdy(add_rdy),
        .drop_vld(drop_vld), .drop_data(drop_data), .drop_rdy(drop_rdy)
    );

    always #2 clk = ~clk;

    // Reference model: what arrived last cycle, and what the ring output should hold.
    bit m_in_v = 0; int m_in_d = 0; logic [PAY_W-1:0] m_in_p = '0;
    bit m_out_v = 0; int m_out_d = 0; logic [PAY_W-1:0] m_out_p = '0;
    string m_out_tag = "R8";
    bit accepted;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Inputs are set before calling; compares at mid-cycle, then advances one edge.
    task automatic step();
        bit e_drop, e_fire, e_rdy;
        string rtag;
        #1;
        e_drop = m_in_v && (m_in_d == ME);
        e_fire = e_drop && drop_rdy;
        e_rdy  = !m_in_v || e_fire;
        rtag   = (m_in_v && !e_drop) ? "R7" : "R5";
        check(m_out_tag, "tx_vld", tx_vld, m_out_v);
        if (m_out_v) begin
            check(m_out_tag, "tx_dest", tx_dest, m_out_d);
            check(m_out_tag, "tx_data", tx_data, m_out_p);
        end
        check("R2", "drop_vld", drop_vld, e_drop);
        if (e_drop) check("R2", "drop_data", drop_data, m_in_p);
        check(rtag, "add_rdy", add_rdy, e_rdy);
        accepted = add_vld && e_rdy;
        @(posedge clk);
        if (m_in_v && !e_fire) begin
            m_out_v = 1; m_out_d = m_in_d; m_out_p = m_in_p;
            m_out_tag = e_drop ? "R4" : "R1";
        end else if (add_vld) begin
            m_out_v = 1; m_out_d = add_dest; m_out_p = add_data; m_out_tag = "R6";
        end else begin
            m_out_v = 0; m_out_tag = e_fire ? "R3" : "R1";
        end
        m_in_v = rx_vld; m_in_d = rx_dest; m_in_p = rx_data;
        @(negedge clk);
    endtask

    task automatic ring(input bit v, input int d, input logic [PAY_W-1:0] p);
        rx_vld = v; rx_dest = DEST_W'(d); rx_data = p;
    endtask

    task automatic offer(input bit v, input int d, input logic [PAY_W-1:0] p);
        add_vld = v; add_dest = DEST_W'(d); add_data = p;
    endtask

    initial begin
        #(4ns * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        #1;
        check("R8", "tx_vld after reset", tx_vld, 0);
        check("R8", "drop_vld after reset", drop_vld, 0);
        check("R8", "add_rdy after reset", add_rdy, 1);
        @(negedge clk);

        // R1: single foreign flit, then idle
        ring(1, 5, 32'hA5A5_0001); step(); ring(0, 0, 0); repeat (3) step();
        // R2, R3: local flit accepted by the consumer
        drop_rdy = 1; ring(1, ME, 32'h1111_2222); step(); ring(0, 0, 0); repeat (3) step();
        // R4: local flit refused, must reappear on the ring
        drop_rdy = 0; ring(1, ME, 32'h3333_4444); step(); ring(0, 0, 0); repeat (3) step();
        drop_rdy = 1;
        // R6: injection into an empty ring
        offer(1, 6, 32'h6666_0000); step(); offer(0, 0, 0); repeat (2) step();
        // R7: busy ring of foreign flits blocks a pending injection
        offer(1, 1, 32'h7777_0001);
        for (int i = 0; i < 4; i++) begin ring(1, 0, 32'hB000_0000 + i); step(); end
        ring(0, 0, 0);
        while (!accepted) step();
        offer(0, 0, 0); repeat (2) step();
        // R5: injection into a slot freed by a drop in the same cycle
        ring(1, ME, 32'hC0DE_0005); step(); ring(0, 0, 0);
        offer(1, 2, 32'h5555_5555); step(); offer(0, 0, 0); repeat (3) step();

        // Mixed random traffic
        for (int c = 0; c < 3000; c++) begin
            bit v;
            v = ($urandom_range(0, 99) < 60);
            ring(v, $urandom_range(0, RING_NODES - 1), $urandom());
            drop_rdy = ($urandom_range(0, 99) < 70);
            if (!add_vld && $urandom_range(0, 99) < 40)
                offer(1, $urandom_range(0, RING_NODES - 1), $urandom());
            step();
            if (accepted) offer(0, 0, 0);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule